// File: doc/BRIEF.md
# Key-Folded Table AES-128 Encryption Datapath

This block encrypts 128-bit blocks with AES using round tables that already contain the round key. For every round and every one of the 16 state bytes there is a 256-entry table whose entry `i` holds `S(i ^ k)`, where `S` is the AES S-box and `k` is that round's key byte for that position. The key addition and the byte substitution therefore collapse into one table read. A round becomes two clock cycles: a registered lookup of all 16 bytes, then a combine cycle that applies the row rotation and the column mix.

Software or a key-expansion engine outside the block fills the tables through a byte-wide write port. The same port loads the final whitening key, which is XORed into the state after the last round. One block is in flight at a time. A plaintext enters through a valid/ready handshake, and the ciphertext is held on a valid/ready output until it is taken. The parameter `RPP` picks how many rounds one pass through the round engine covers before the state recirculates. Each round slot owns its own table banks and its own combine network.

Top module: `aes_kf_core`

## Requirements
- R1: While `rst_ni` is low and after its release, `in_ready_o` is 1, `out_valid_o` is 0 and `out_data_o` is all zero.
- R2: Setup for this check:
  - Round `r` (0..NR-1), position `p`, entry `i` is loaded with `S(i ^ k_r[p])`.
  - Write index `NR` position `p` is loaded with the final key byte `k_NR[p]`.
  - Byte `p` of every 128-bit word sits at bits `[127-8p -: 8]`, which is row `p%4`, column `p/4`.

  With that setup, `out_data_o` is the AES-128 encryption of the accepted `in_data_i`. Key `000102..0f` with plaintext `00112233..ff` gives `69c4e0d86a7b0430d8cdb78070b4c55a`.
- R3: `out_valid_o` rises exactly `2*NR` rising clock edges after the edge that accepts a block (one lookup and one combine edge per round). `in_ready_o` stays 0 from the accepting edge until the output handshake edge, after which it is 1 again.
- R4: The last round applies no column mix, and the final key is XORed bytewise into the output. Changing final key byte `p` by a value `d` changes only output byte `p`, by exactly `d`.
- R5: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` stays 1 and `out_data_o` is stable.
- R6: `in_valid_i` and `in_data_i` have no effect while a block is in flight. The result is that of the block accepted earlier.
- R7: Suppose a table write and that table's lookup read of the same entry fall on the same edge. The lookup returns the entry's previous content, and the written value is used by every later lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Plaintext valid |
| in_ready_o | output | 1 | Block can accept a plaintext |
| in_data_i | input | 128 | Plaintext, byte 0 in bits 127:120 |
| out_valid_o | output | 1 | Ciphertext valid |
| out_ready_i | input | 1 | Consumer takes the ciphertext |
| out_data_o | output | 128 | Ciphertext, byte 0 in bits 127:120 |
| tw_en_i | input | 1 | Table or final-key write strobe |
| tw_round_i | input | RW | Round index 0..NR-1, or NR for the final key |
| tw_pos_i | input | 4 | State byte position 0..15 |
| tw_idx_i | input | 8 | Table entry address (ignored for the final key) |
| tw_data_i | input | 8 | Byte to write |

## Verification
A table write and a table lookup can fall on the same edge. Both can even address the same entry, because the write port works independently of the round sequencer.

The bench provokes this collision deliberately. It places a write to round 0, position 0 on the exact lookup edge of round 0, at the entry addressed by plaintext byte 0. It then judges the result in three steps:
1. The ciphertext of that block must still match the known answer, because the old content was read.
2. The next block with the same plaintext must differ from the known answer.
3. After the entry is restored, the known answer must return.

// File: rtl/aes_kf_pkg.sv
package aes_kf_pkg;
  localparam int unsigned NB = 16;
  localparam int unsigned BW = 8;
  localparam int unsigned BLK = NB * BW;

  typedef logic [BW-1:0] byte_t;
  typedef byte_t [NB-1:0] state_t;

  typedef enum logic [1:0] {PH_IDLE, PH_LOOK, PH_MIX, PH_DONE} phase_e;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic byte_t xt(input byte_t b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  // byte p of a block lives at bits [127-8p -: 8]
  function automatic state_t from_block(input logic [BLK-1:0] v);
    state_t s;
    for (int p = 0; p < NB; p++) s[p] = v[BLK-1-BW*p -: BW];
    return s;
  endfunction

  function automatic logic [BLK-1:0] to_block(input state_t s);
    logic [BLK-1:0] v;
    for (int p = 0; p < NB; p++) v[BLK-1-BW*p -: BW] = s[p];
    return v;
  endfunction
endpackage

// File: rtl/kf_bank.sv
module kf_bank #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // read-before-write on a shared edge
  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= mem_q[raddr_i];
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
endmodule

// File: rtl/kf_mix.sv
module kf_mix import aes_kf_pkg::*; (
  input  state_t y_i,
  input  logic   last_i,
  output state_t z_o
);
  state_t sh;
  state_t mx;

  always_comb begin
    // row r of column c takes the byte from column (c+r) mod 4
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        sh[4*c+r] = y_i[4*((c+r)%4)+r];
  end

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      byte_t a0, a1, a2, a3;
      a0 = sh[4*c];
      a1 = sh[4*c+1];
      a2 = sh[4*c+2];
      a3 = sh[4*c+3];
      mx[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      mx[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      mx[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      mx[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
  end

  assign z_o = last_i ? sh : mx;
endmodule

// File: rtl/kf_slot.sv
module kf_slot import aes_kf_pkg::*; #(
  parameter int unsigned NR   = 10,
  parameter int unsigned RPP  = 2,
  parameter int unsigned SLOT = 0,
  localparam int unsigned RW    = $clog2(NR + 1),
  localparam int unsigned NBANK = NR / RPP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          look_i,
  input  logic [RW-1:0] rnd_i,
  input  state_t        st_i,
  input  logic          tw_en_i,
  input  logic [RW-1:0] tw_round_i,
  input  logic [3:0]    tw_pos_i,
  input  byte_t         tw_idx_i,
  input  byte_t         tw_data_i,
  output state_t        lk_o
);
  byte_t            q [NBANK][NB];
  logic [NBANK-1:0] re_vec;
  logic [RW-1:0]    sel_q;

  for (genvar k = 0; k < NBANK; k++) begin : g_rnd
    localparam int unsigned ROUND = SLOT + k * RPP;
    assign re_vec[k] = look_i && (rnd_i == RW'(ROUND));
    for (genvar p = 0; p < NB; p++) begin : g_pos
      kf_bank #(.DEPTH(256), .DW(BW)) u_bank (
        .clk_i   (clk_i),
        .we_i    (tw_en_i && (tw_round_i == RW'(ROUND)) && (tw_pos_i == 4'(p))),
        .waddr_i (tw_idx_i),
        .wdata_i (tw_data_i),
        .re_i    (re_vec[k]),
        .raddr_i (st_i[p]),
        .rdata_o (q[k][p])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (look_i) sel_q <= rnd_i;
  end

  always_comb begin
    lk_o = '0;
    for (int k = 0; k < NBANK; k++)
      if (sel_q == RW'(SLOT + k * RPP))
        for (int p = 0; p < NB; p++) lk_o[p] = q[k][p];
  end

  // only the tables of one round are read per lookup (R2)
  assert_one_round_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(re_vec)) else $error("two round banks read at once");
endmodule

// File: rtl/aes_kf_core.sv
module aes_kf_core import aes_kf_pkg::*; #(
  parameter int unsigned NR  = 10,
  parameter int unsigned RPP = 2,
  localparam int unsigned RW = $clog2(NR + 1),
  localparam int unsigned SW = (RPP > 1) ? $clog2(RPP) : 1,
  localparam int unsigned LW = $clog2(2 * NR + 3)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [BLK-1:0] in_data_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [BLK-1:0] out_data_o,
  input  logic           tw_en_i,
  input  logic [RW-1:0]  tw_round_i,
  input  logic [3:0]     tw_pos_i,
  input  logic [7:0]     tw_idx_i,
  input  logic [7:0]     tw_data_i
);
  phase_e          phase_q;
  state_t          st_q;
  state_t          fin_q;
  state_t          nxt;
  logic [RW-1:0]   rnd_q;
  logic [SW-1:0]   sl_q;
  logic [BLK-1:0]  out_q;
  logic            last_rnd;
  state_t          lk    [RPP];
  state_t          mixed [RPP];

  assign last_rnd = (rnd_q == RW'(NR - 1));

  for (genvar j = 0; j < RPP; j++) begin : g_slot
    kf_slot #(.NR(NR), .RPP(RPP), .SLOT(j)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .look_i     (phase_q == PH_LOOK),
      .rnd_i      (rnd_q),
      .st_i       (st_q),
      .tw_en_i    (tw_en_i),
      .tw_round_i (tw_round_i),
      .tw_pos_i   (tw_pos_i),
      .tw_idx_i   (tw_idx_i),
      .tw_data_i  (tw_data_i),
      .lk_o       (lk[j])
    );
    kf_mix u_mix (
      .y_i    (lk[j]),
      .last_i (last_rnd),
      .z_o    (mixed[j])
    );
  end

  always_comb begin
    nxt = mixed[0];
    for (int j = 0; j < RPP; j++)
      if (sl_q == SW'(j)) nxt = mixed[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_q <= '0;
    end else if (tw_en_i && (tw_round_i == RW'(NR))) begin
      fin_q[tw_pos_i] <= tw_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      st_q    <= '0;
      rnd_q   <= '0;
      sl_q    <= '0;
      out_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (in_valid_i) begin
          st_q    <= from_block(in_data_i);
          rnd_q   <= '0;
          sl_q    <= '0;
          phase_q <= PH_LOOK;
        end
        PH_LOOK: phase_q <= PH_MIX;
        PH_MIX: begin
          st_q <= nxt;
          if (last_rnd) begin
            out_q   <= to_block(nxt ^ fin_q);
            phase_q <= PH_DONE;
          end else begin
            rnd_q   <= rnd_q + RW'(1);
            sl_q    <= (sl_q == SW'(RPP - 1)) ? '0 : sl_q + SW'(1);
            phase_q <= PH_LOOK;
          end
        end
        PH_DONE: if (out_ready_i) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign in_ready_o  = (phase_q == PH_IDLE);
  assign out_valid_o = (phase_q == PH_DONE);
  assign out_data_o  = out_q;

  // cycle count since acceptance, for the latency check only
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       lat_q <= '0;
    else if (in_valid_i && in_ready_o)                 lat_q <= LW'(1);
    else if (phase_q == PH_LOOK || phase_q == PH_MIX)  lat_q <= lat_q + LW'(1);
  end

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (lat_q == LW'(2 * NR + 1))) else $error("latency off");

  assert_no_ready_with_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o) else $error("ready while output pending");

  assert_out_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)))
    else $error("output dropped under backpressure");

  assert_busy_blocks_input_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o) else $error("accepted while busy");

  assert_round_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_q < RW'(NR)) else $error("round index out of range");
endmodule

// File: tb/sim_aes_kf_core.sv
`timescale 1ns/1ps
module sim_aes_kf_core;
  localparam int NR  = 10;
  localparam int RPP = 2;
  localparam int RW  = $clog2(NR + 1);
  localparam logic [127:0] KEY   = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] KA_PT = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] KA_CT = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] VEC [5] = '{
    128'h00112233445566778899aabbccddeeff,
    128'h00000000000000000000000000000000,
    128'hffffffffffffffffffffffffffffffff,
    128'h3243f6a8885a308d313198a2e0370734,
    128'h80000000000000000000000000000001
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [127:0]  in_data_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic [127:0]  out_data_o;
  logic          tw_en_i = 1'b0;
  logic [RW-1:0] tw_round_i = '0;
  logic [3:0]    tw_pos_i = '0;
  logic [7:0]    tw_idx_i = '0;
  logic [7:0]    tw_data_i = '0;

  int checks = 0;
  int errors = 0;
  bit rdy_busy;
  bit hold_bad;

  always #2 clk_i = ~clk_i;

  aes_kf_core #(.NR(NR), .RPP(RPP)) u0 (.*);

  logic [7:0]   sbox [256];
  logic [127:0] rk   [NR+1];

  function automatic logic [7:0] gx(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[0]) r ^= a;
      a = gx(a);
      b = b >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] kb(input int r, input int p);
    return rk[r][127-8*p -: 8];
  endfunction

  task automatic build_model();
    logic [31:0] w [44];
    logic [7:0]  rc;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] b;
      if (x != 0)
        for (int y = 1; y < 256; y++)
          if (gmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      b = inv;
      sbox[x] = b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                ^ {b[3:0], b[7:4]} ^ 8'h63;
    end
    for (int i = 0; i < 4; i++) w[i] = KEY[127-32*i -: 32];
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t;
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sbox[t[31:24]], sbox[t[23:16]], sbox[t[15:8]], sbox[t[7:0]]} ^ {rc, 24'h0};
        rc = gx(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= NR; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] o;
    for (int p = 0; p < 16; p++) s[p] = pt[127-8*p -: 8] ^ kb(0, p);
    for (int r = 1; r <= NR; r++) begin
      for (int p = 0; p < 16; p++) t[p] = sbox[s[p]];
      for (int c = 0; c < 4; c++)
        for (int q = 0; q < 4; q++) s[4*c+q] = t[4*((c+q)%4)+q];
      if (r < NR)
        for (int c = 0; c < 4; c++) begin
          logic [7:0] a0, a1, a2, a3;
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = gmul(a0, 8'h02) ^ gmul(a1, 8'h03) ^ a2 ^ a3;
          s[4*c+1] = a0 ^ gmul(a1, 8'h02) ^ gmul(a2, 8'h03) ^ a3;
          s[4*c+2] = a0 ^ a1 ^ gmul(a2, 8'h02) ^ gmul(a3, 8'h03);
          s[4*c+3] = gmul(a0, 8'h03) ^ a1 ^ a2 ^ gmul(a3, 8'h02);
        end
      for (int p = 0; p < 16; p++) s[p] ^= kb(r, p);
    end
    for (int p = 0; p < 16; p++) o[127-8*p -: 8] = s[p];
    return o;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tw(input int r, input int p, input int i, input logic [7:0] d);
    @(negedge clk_i);
    tw_en_i = 1'b1; tw_round_i = RW'(r); tw_pos_i = 4'(p); tw_idx_i = 8'(i); tw_data_i = d;
    @(negedge clk_i);
    tw_en_i = 1'b0;
  endtask

  // poke: write tw_data on the round-0 lookup edge at the entry addressed by byte 0
  task automatic run_block(input logic [127:0] pt, input bit junk, input int hold,
                           input bit poke, input logic [7:0] poke_d,
                           output logic [127:0] ct, output int lat);
    logic [127:0] snap;
    rdy_busy = 1'b0;
    hold_bad = 1'b0;
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_data_i  = pt;
    @(posedge clk_i);
    @(negedge clk_i);
    if (junk) in_data_i = ~pt;
    else      in_valid_i = 1'b0;
    if (poke) begin
      tw_en_i = 1'b1; tw_round_i = '0; tw_pos_i = 4'd0;
      tw_idx_i = pt[127:120]; tw_data_i = poke_d;
    end
    lat = 0;
    while (!out_valid_o && lat < 200) begin
      if (in_ready_o) rdy_busy = 1'b1;
      @(posedge clk_i);
      lat++;
      @(negedge clk_i);
      tw_en_i = 1'b0;
    end
    in_valid_i = 1'b0;
    snap = out_data_o;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (!out_valid_o || out_data_o !== snap) hold_bad = 1'b1;
    end
    ct = out_data_o;
    out_ready_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    out_ready_i = 1'b0;
    if (!in_ready_o || out_valid_o) rdy_busy = 1'b1;
  endtask

  initial begin : wd
    repeat (190000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [127:0] ct, exp;
    int lat;
    logic [7:0] orig;

    build_model();
    repeat (3) @(negedge clk_i);
    // R1 during reset
    check("R1", {127'd0, in_ready_o}, 128'd1, "in_ready in reset");
    check("R1", {127'd0, out_valid_o}, 128'd0, "out_valid in reset");
    check("R1", out_data_o, 128'd0, "out_data in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {126'd0, in_ready_o, out_valid_o}, 128'd2, "ready/valid after reset");

    check("R2", ref_enc(KA_PT), KA_CT, "bench model known answer");

    for (int r = 0; r < NR; r++)
      for (int p = 0; p < 16; p++)
        for (int i = 0; i < 256; i++) begin
          @(negedge clk_i);
          tw_en_i = 1'b1; tw_round_i = RW'(r); tw_pos_i = 4'(p);
          tw_idx_i = 8'(i); tw_data_i = sbox[8'(i) ^ kb(r, p)];
        end
    for (int p = 0; p < 16; p++) begin
      @(negedge clk_i);
      tw_en_i = 1'b1; tw_round_i = RW'(NR); tw_pos_i = 4'(p);
      tw_idx_i = 8'h00; tw_data_i = kb(NR, p);
    end
    @(negedge clk_i);
    tw_en_i = 1'b0;
    check("R1", out_data_o, 128'd0, "no output from table loading");

    // vector walk: R2 result, R3 latency and ready
    for (int v = 0; v < 5; v++) begin
      run_block(VEC[v], 1'b0, 0, 1'b0, 8'h00, ct, lat);
      check("R2", ct, ref_enc(VEC[v]), $sformatf("ciphertext vector %0d", v));
      check("R3", 128'(lat), 128'(2 * NR), $sformatf("latency vector %0d", v));
      check("R3", {127'd0, rdy_busy}, 128'd0, $sformatf("ready while busy vector %0d", v));
    end

    run_block(KA_PT, 1'b0, 0, 1'b0, 8'h00, ct, lat);
    check("R2", ct, KA_CT, "known answer ciphertext");

    // R5 backpressure
    run_block(VEC[3], 1'b0, 6, 1'b0, 8'h00, ct, lat);
    check("R5", {127'd0, hold_bad}, 128'd0, "hold under backpressure");
    check("R5", ct, ref_enc(VEC[3]), "held ciphertext");

    // R6 input while busy is ignored
    run_block(VEC[4], 1'b1, 2, 1'b0, 8'h00, ct, lat);
    check("R6", ct, ref_enc(VEC[4]), "result ignores busy input");
    check("R6", {127'd0, rdy_busy}, 128'd0, "no accept while busy");
    run_block(VEC[1], 1'b0, 0, 1'b0, 8'h00, ct, lat);
    check("R6", ct, ref_enc(VEC[1]), "next block after ignored input");

    // R4 final key affects only its own output byte
    tw(NR, 5, 0, kb(NR, 5) ^ 8'ha5);
    run_block(KA_PT, 1'b0, 0, 1'b0, 8'h00, ct, lat);
    exp = KA_CT;
    exp[127-8*5 -: 8] = exp[127-8*5 -: 8] ^ 8'ha5;
    check("R4", ct, exp, "final key byte 5 delta");
    tw(NR, 5, 0, kb(NR, 5));
    run_block(KA_PT, 1'b0, 0, 1'b0, 8'h00, ct, lat);
    check("R4", ct, KA_CT, "final key restored");

    // R7 write colliding with lookup of the same entry
    orig = sbox[KA_PT[127:120] ^ kb(0, 0)];
    run_block(KA_PT, 1'b0, 0, 1'b1, orig ^ 8'h5a, ct, lat);
    check("R7", ct, KA_CT, "collision lookup uses old entry");
    run_block(KA_PT, 1'b0, 0, 1'b0, 8'h00, ct, lat);
    check("R7", {127'd0, ct != KA_CT}, 128'd1, "later lookup uses new entry");
    tw(0, 0, KA_PT[127:120], orig);
    run_block(KA_PT, 1'b0, 0, 1'b0, 8'h00, ct, lat);
    check("R7", ct, KA_CT, "entry restored");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule